// File: doc/BRIEF.md
# Dual-Format Serial Command Receiver

This block sits between a host's slow serial port and a command executor inside a trim-DAC style device. It runs on a fast system clock and oversamples the serial clock, data input and the shared chip-select/load line. A static format input picks one of two framings. In framed mode the host drops chip select, clocks in a 16-bit word starting with bit 0, and raises chip select to commit the word. In load mode the host shifts a 14-bit word in, most significant bit first, and commits it with a high pulse on the load line. In load mode the two bank-address bits come from two dedicated pins.

A committed word is split into a 2-bit control field, a 2-bit bank field, a 4-bit channel field and an 8-bit data field. It is presented with a one-cycle valid strobe. The serial output carries one of three things: read data handed over by the executor, the executor's ready/busy state, or nothing (output disabled).

In framed mode, the level of the serial clock at the moment chip select falls decides the kind of transaction. A high clock opens a data-entry frame. A low clock opens a status poll.

Top module: `sercmd_rx_top`

## Requirements
- R1: In framed mode (fmt_sel_i=1), the first serial bit is word bit 0. A committed 16-bit word w gives ctrl=w[15:14], bank=w[13:12], chan=w[11:8] and data=w[7:0].
- R2: In load mode (fmt_sel_i=0), bits arrive most significant first. A rising load line commits the last 14 bits w as ctrl=w[13:12], chan=w[11:8] and data=w[7:0], with bank taken from bank_pin_i.
- R3: In framed mode, a chip-select fall while the serial clock is high opens an entry frame. Data is sampled on serial-clock rising edges, and the chip-select rise commits the word.
- R4: An entry frame with any number of rising edges other than exactly 16 is dropped and produces no strobe.
- R5: A chip-select fall while the serial clock is low opens a status poll. During the poll DO is 1 when busy_i=0 and 0 when busy_i=1, and serial-clock edges load no bits.
- R6: A chip-select rise ends a status poll whatever the serial-clock level. No strobe follows, and the next frame behaves normally.
- R7: In framed mode, sdo_oe_o is 0 while chip select is high and 1 while it is low.
- R8: rd_valid_i loads rd_data_i into the output register. In framed mode DO shows bit 0 first and advances one bit on each serial-clock falling edge of an entry frame.
- R9: In load mode, sdo_oe_o is always 1. DO shows the read data MSB first, advancing on serial-clock falls, and is forced to 0 while busy_i=1.
- R10: cmd_valid_o is high for exactly one system-clock cycle per committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel_i | input | 1 | 1 = framed 16-bit, 0 = load-pulse 14-bit; held static |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| csld_i | input | 1 | Chip select (framed) or load strobe (load mode) |
| bank_pin_i | input | 2 | Bank address used in load mode |
| busy_i | input | 1 | Executor busy flag |
| rd_valid_i | input | 1 | Load rd_data_i into the output register |
| rd_data_i | input | 8 | Read data to shift out |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_ctrl_o | output | 2 | Control field |
| cmd_bank_o | output | 2 | Bank field |
| cmd_chan_o | output | 4 | Channel field |
| cmd_data_o | output | 8 | Data field |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
The assertions watch four things every cycle: the strobe is a single cycle, a frame with a wrong bit count never strobes, the input register holds still during a status poll, and the output enable and status level follow chip select, the format and busy. Several behaviours can only be shown by the bench's scenarios. These are the field placement for both bit orders, the bank value coming from the pins in load mode, the bit-by-bit order of shifted-out read data, and the recovery from a status poll into a normal frame.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int CTRL_W = 2;
  localparam int BANK_W = 2;
  localparam int CHAN_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {FM_IDLE, FM_ENTRY, FM_STATUS} fmode_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{INIT}};
      last <= INIT;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
  parameter int WMAX  = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             lsb_first,
  input  logic             bit_in,
  output logic [WMAX-1:0]  word_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word_o <= '0;
      cnt_o  <= '0;
    end else if (shift_en) begin
      if (lsb_first) word_o <= {bit_in, word_o[WMAX-1:1]};
      else           word_o <= {word_o[WMAX-2:0], bit_in};
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R4: the bit count advances by one per accepted edge so a short/long frame is seen
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/dout_ctrl.sv
module dout_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          framed,
  input  logic          cs_lvl,
  input  logic          status,
  input  logic          shift_en,
  input  logic          busy,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  logic [DW-1:0] out_q;
  logic          sdo_d;

  always_ff @(posedge clk) begin
    if (rst)           out_q <= '0;
    else if (rd_valid) out_q <= rd_data;
    else if (shift_en) out_q <= framed ? (out_q >> 1) : (out_q << 1);
  end

  always_comb begin
    if (framed) begin
      if (cs_lvl)      sdo_d = 1'b0;
      else if (status) sdo_d = ~busy;
      else             sdo_d = out_q[0];
    end else begin
      sdo_d = busy ? 1'b0 : out_q[DW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      sdo_o    <= sdo_d;
      sdo_oe_o <= framed ? ~cs_lvl : 1'b1;
    end
  end

  p_oe_off_r7: assert property (@(posedge clk) disable iff (rst)
    (framed && cs_lvl) |=> !sdo_oe_o);
  p_status_lvl_r5: assert property (@(posedge clk) disable iff (rst)
    (framed && !cs_lvl && status) |=> (sdo_o == !$past(busy)));
  p_load_oe_r9: assert property (@(posedge clk) disable iff (rst)
    (!framed) |=> sdo_oe_o);
  p_load_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (!framed && busy) |=> !sdo_o);
endmodule

// File: rtl/sercmd_rx_top.sv
module sercmd_rx_top
  import sercmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_sel_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              csld_i,
  input  logic [BANK_W-1:0] bank_pin_i,
  input  logic              busy_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [CTRL_W-1:0] cmd_ctrl_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [CHAN_W-1:0] cmd_chan_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int FRAME_BITS = CTRL_W + BANK_W + CHAN_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam int CHAN_LO    = DATA_W;
  localparam int BANK_LO    = DATA_W + CHAN_W;
  localparam int CTRL_LO_F  = BANK_LO + BANK_W;
  localparam int CTRL_LO_L  = DATA_W + CHAN_W;

  logic fmt_q;
  logic sck_lvl, sck_rise, sck_fall;
  logic cs_lvl, cs_rise, cs_fall;
  logic [SYNC_STAGES-1:0] di_pipe;
  logic di_s;
  fmode_e mode;
  logic [FRAME_BITS-1:0] word;
  logic [CNT_W-1:0] cnt;
  logic in_shift, out_shift, frame_clr;

  always_ff @(posedge clk) begin
    if (rst) fmt_q <= 1'b1;
    else     fmt_q <= fmt_sel_i;
  end

  sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sck (
    .clk(clk), .rst(rst), .din(sck_i),
    .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));

  sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs (
    .clk(clk), .rst(rst), .din(csld_i),
    .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));

  always_ff @(posedge clk) begin
    if (rst) di_pipe <= '0;
    else     di_pipe <= {di_pipe[SYNC_STAGES-2:0], sdi_i};
  end
  assign di_s = di_pipe[SYNC_STAGES-1];

  // Framed-mode transaction state
  always_ff @(posedge clk) begin
    if (rst || !fmt_q)  mode <= FM_IDLE;
    else if (cs_fall)   mode <= sck_lvl ? FM_ENTRY : FM_STATUS;
    else if (cs_rise)   mode <= FM_IDLE;
  end

  assign frame_clr = fmt_q & cs_fall;
  assign in_shift  = sck_rise & (fmt_q ? (mode == FM_ENTRY) : 1'b1);
  assign out_shift = sck_fall & (fmt_q ? (mode == FM_ENTRY) : 1'b1);

  cmd_shifter #(.WMAX(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .clr(frame_clr), .shift_en(in_shift),
    .lsb_first(fmt_q), .bit_in(di_s), .word_o(word), .cnt_o(cnt));

  // Command commit
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_o <= 1'b0;
      cmd_ctrl_o  <= '0;
      cmd_bank_o  <= '0;
      cmd_chan_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (fmt_q) begin
        if (cs_rise && mode == FM_ENTRY && cnt == FULL_CNT) begin
          cmd_valid_o <= 1'b1;
          cmd_ctrl_o  <= word[CTRL_LO_F +: CTRL_W];
          cmd_bank_o  <= word[BANK_LO +: BANK_W];
          cmd_chan_o  <= word[CHAN_LO +: CHAN_W];
          cmd_data_o  <= word[0 +: DATA_W];
        end
      end else if (cs_rise) begin
        cmd_valid_o <= 1'b1;
        cmd_ctrl_o  <= word[CTRL_LO_L +: CTRL_W];
        cmd_bank_o  <= bank_pin_i;
        cmd_chan_o  <= word[CHAN_LO +: CHAN_W];
        cmd_data_o  <= word[0 +: DATA_W];
      end
    end
  end

  dout_ctrl #(.DW(DATA_W)) u_dout (
    .clk(clk), .rst(rst), .framed(fmt_q), .cs_lvl(cs_lvl),
    .status(mode == FM_STATUS), .shift_en(out_shift), .busy(busy_i),
    .rd_valid(rd_valid_i), .rd_data(rd_data_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);
  p_discard_r4: assert property (@(posedge clk) disable iff (rst)
    (fmt_q && cs_rise && cnt != FULL_CNT) |=> !cmd_valid_o);
  p_status_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_STATUS) |=> $stable(word));
  p_status_exit_r6: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (mode == FM_IDLE));
  p_entry_open_r3: assert property (@(posedge clk) disable iff (rst)
    (fmt_q && fmt_sel_i && cs_fall && sck_lvl) |=> (mode == FM_ENTRY));
endmodule

// File: tb/sim_sercmd_rx_top.sv
module sim_sercmd_rx_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fmt_sel_i = 1'b1, sck_i = 1'b1, sdi_i = 1'b0, csld_i = 1'b1;
  logic [1:0] bank_pin_i = 2'b00;
  logic busy_i = 1'b0, rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic cmd_valid_o, sdo_o, sdo_oe_o;
  logic [1:0] cmd_ctrl_o, cmd_bank_o;
  logic [3:0] cmd_chan_o;
  logic [7:0] cmd_data_o;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic prev_valid = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sercmd_rx_top u0 (
    .clk(clk), .rst(rst), .fmt_sel_i(fmt_sel_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .csld_i(csld_i), .bank_pin_i(bank_pin_i), .busy_i(busy_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ctrl_o(cmd_ctrl_o), .cmd_bank_o(cmd_bank_o), .cmd_chan_o(cmd_chan_o),
    .cmd_data_o(cmd_data_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected commands as strobes appear (R1 R2 R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid_o) begin
        chk(!prev_valid, "R10 strobe width", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected strobe",
              {cmd_ctrl_o, cmd_bank_o, cmd_chan_o, cmd_data_o}, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({cmd_ctrl_o, cmd_bank_o, cmd_chan_o, cmd_data_o} == e,
              "R1/R2 command fields",
              {cmd_ctrl_o, cmd_bank_o, cmd_chan_o, cmd_data_o}, e);
        end
      end
      prev_valid <= cmd_valid_o;
    end
  end

  task automatic do_reset(input logic fmt);
    rst = 1'b1; fmt_sel_i = fmt; csld_i = fmt; sck_i = fmt; sdi_i = 1'b0;
    wt(5);
    rst = 1'b0;
    wt(10);
  endtask

  // Framed frame: nbits rising edges, LSB first; push expected when nbits==16
  task automatic framed_frame(input logic [15:0] w, input int nbits);
    if (nbits == 16) exp_q.push_back(w);
    sck_i = 1'b1; wt(H);
    csld_i = 1'b0; wt(H);
    for (int i = 0; i < nbits; i++) begin
      sck_i = 1'b0; sdi_i = (i < 16) ? w[i] : 1'b0; wt(H);
      sck_i = 1'b1; wt(H);
    end
    csld_i = 1'b1; wt(2*H);
  endtask

  task automatic load_frame(input logic [13:0] w, input logic [1:0] bk);
    exp_q.push_back({w[13:12], bk, w[11:0]});
    bank_pin_i = bk;
    for (int i = 13; i >= 0; i--) begin
      sck_i = 1'b0; sdi_i = w[i]; wt(H);
      sck_i = 1'b1; wt(H);
    end
    csld_i = 1'b1; wt(H);
    csld_i = 1'b0; wt(2*H);
  endtask

  task automatic load_rd(input logic [7:0] d);
    rd_data_i = d; rd_valid_i = 1'b1; wt(1);
    rd_valid_i = 1'b0; wt(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Framed mode reset state (R7)
    do_reset(1'b1);
    chk(sdo_oe_o == 1'b0, "R7 oe off at idle", sdo_oe_o, 0);
    chk(cmd_valid_o == 1'b0, "R10 no strobe after reset", cmd_valid_o, 0);

    // R1 R3: good framed words
    framed_frame(16'hA5C3, 16);
    framed_frame(16'h1E7F, 16);
    framed_frame(16'h8001, 16);
    // R4: wrong lengths dropped
    framed_frame(16'hFFFF, 15);
    framed_frame(16'hFFFF, 17);
    chk(exp_q.size() == 0, "R3 framed strobes consumed", exp_q.size(), 0);

    // R5 status poll: CS falls with CLK low
    sck_i = 1'b0; wt(H);
    busy_i = 1'b0; csld_i = 1'b0; wt(H);
    chk(sdo_oe_o == 1'b1, "R7 oe on while selected", sdo_oe_o, 1);
    chk(sdo_o == 1'b1, "R5 ready level", sdo_o, 1);
    busy_i = 1'b1; wt(H);
    chk(sdo_o == 1'b0, "R5 busy level", sdo_o, 0);
    for (int i = 0; i < 16; i++) begin
      sck_i = 1'b1; sdi_i = 1'b1; wt(H);
      sck_i = 1'b0; wt(H);
    end
    busy_i = 1'b0; wt(H);
    chk(sdo_o == 1'b1, "R5 ready again", sdo_o, 1);
    // R6: CS rises with CLK low, no strobe (monitor would flag it)
    csld_i = 1'b1; wt(2*H);
    chk(sdo_oe_o == 1'b0, "R6/R7 oe off after poll", sdo_oe_o, 0);
    framed_frame(16'h3C96, 16);
    chk(exp_q.size() == 0, "R6 frame after poll committed", exp_q.size(), 0);

    // R8 framed read-out, LSB first
    load_rd(8'hB4);
    sck_i = 1'b1; wt(H);
    csld_i = 1'b0; wt(H);
    chk(sdo_o == 1'b0, "R8 read bit0", sdo_o, 0);
    for (int k = 1; k < 8; k++) begin
      sck_i = 1'b0; wt(H);
      chk(sdo_o == rd_data_i[k], "R8 read bit", sdo_o, rd_data_i[k]);
      sck_i = 1'b1; wt(H);
    end
    csld_i = 1'b1; wt(2*H);

    // Load mode
    do_reset(1'b0);
    chk(sdo_oe_o == 1'b1, "R9 oe on in load mode", sdo_oe_o, 1);
    load_frame(14'h2A5C, 2'b10);
    load_frame(14'h13F0, 2'b01);
    load_frame(14'h3FFF, 2'b11);
    chk(exp_q.size() == 0, "R2 load strobes consumed", exp_q.size(), 0);

    // R9 busy forces 0, read-out MSB first
    load_rd(8'hC3);
    chk(sdo_o == 1'b1, "R9 msb first", sdo_o, 1);
    busy_i = 1'b1; wt(H);
    chk(sdo_o == 1'b0, "R9 busy forces low", sdo_o, 0);
    chk(sdo_oe_o == 1'b1, "R9 oe during busy", sdo_oe_o, 1);
    busy_i = 1'b0; wt(H);
    for (int k = 6; k >= 0; k--) begin
      sck_i = 1'b0; wt(H);
      chk(sdo_o == rd_data_i[k], "R9 read bit", sdo_o, rd_data_i[k]);
      sck_i = 1'b1; wt(H);
    end
    wt(4*H);
    chk(exp_q.size() == 0, "R4 no pending commands", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule